// File: doc/BRIEF.md
# Read-Once Secret Word Store

This block keeps a small device secret, eight words of 32 bits each, and hands each word out over a simple memory-mapped read port. The port has a chip select, a write enable, a word address, and a registered data/ready pair. Each word comes out intact on the first read after reset. From then on, every later read of that word returns zero. Each word is tracked on its own, so words may be fetched in any order. Only a reset gives access to the secret again.

The secret value comes in as a parameter. Word `i` sits in bits `[i*WORD_W +: WORD_W]` of `SECRET` and answers at address `BASE_ADDR + i`. There is no write path into the secret.

Top module: `secret_once_store`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `ready` and `rdata` are 0 after that edge. The reset is synchronous and active low.
- R2: A read request is `cs`=1 and `we`=0 at a rising edge. On the first read of address `BASE_ADDR+i` (i in 0..7) since reset, the next edge drives `ready`=1 and `rdata` = word i of `SECRET`.
- R3: Any later read of a word that has already been read gives `ready`=1 and `rdata`=0. This includes a read held on the same address in the very next cycle.
- R4: Each word has its own "already read" flag. Reading one word never blocks the first read of another, in any address order.
- R5: A reset clears every flag, so each word can again be read once with its true value.
- R6: `ready` is 1 exactly in the cycle after each read request and 0 otherwise. `rdata` is 0 whenever `ready` is 0.
- R7: A write request (`cs`=1, `we`=1) produces no `ready` and alters no flag. A first read after any number of writes still returns the true word.
- R8: A read of an address outside `BASE_ADDR..BASE_ADDR+7` gives `ready`=1 and `rdata`=0, and it sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all read flags |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable; a request with it high is ignored |
| addr | input | ADDR_W (8) | Word address |
| rdata | output | WORD_W (32) | Read data, registered; zero unless a first in-window read |
| ready | output | 1 | One-cycle pulse following each read request |

## Verification
The bench goes after a second read of the same word, including one held back-to-back on the same address. A design that cleared data one cycle late, or forgot to set the flag, would leak the secret twice. It reads the words in a scrambled order after reset and checks that every word still comes out whole. That catches a single shared flag or a flag indexed by the wrong word. It also sends writes and out-of-window reads before the first in-window reads. A design that let those set flags, or answer with data or ready, would then return zeros or spurious pulses.

// File: rtl/secret_once_store.sv
module secret_once_store #(
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
  parameter logic [NUM_WORDS*WORD_W-1:0] SECRET =
    256'h87878787_96969696_a5a5a5a5_b4b4b4b4_c3c3c3c3_d2d2d2d2_e1e1e1e1_f0f0f0f0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rdata,
  output logic              ready
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS);

  logic [WORD_W-1:0] words [NUM_WORDS];
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    assign words[i] = SECRET[i*WORD_W +: WORD_W];
  end

  logic [NUM_WORDS-1:0] used_q;
  logic [ADDR_W-1:0]    off;
  logic [IDX_W-1:0]     idx;
  logic                 rd_req, in_win, fresh;

  assign rd_req = cs && !we;
  assign off    = addr - BASE_ADDR;
  assign idx    = off[IDX_W-1:0];
  assign in_win = (addr >= BASE_ADDR) && (off < SPAN);
  assign fresh  = rd_req && in_win && !used_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      ready  <= 1'b0;
      rdata  <= '0;
    end else begin
      ready <= rd_req;
      rdata <= fresh ? words[idx] : '0;
      if (rd_req && in_win) used_q[idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/secret_once_store_chk.sv
module secret_once_store_chk #(
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [WORD_W-1:0] rdata,
  input logic              ready
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS);
  logic req, outside;
  logic [ADDR_W-1:0] rel;
  assign req     = cs && !we;
  assign rel     = addr - BASE_ADDR;
  assign outside = (addr < BASE_ADDR) || (rel >= SPAN);

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (!ready && rdata == '0));
  p_ready_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n) req |=> ready);
  p_no_ready_else_r6: assert property (@(posedge clk) disable iff (!rst_n) !req |=> !ready);
  p_zero_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> rdata == '0);
  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n) (cs && we) |=> (!ready && rdata == '0));
  p_outside_zero_r8: assert property (@(posedge clk) disable iff (!rst_n) (req && outside) |=> rdata == '0);
  p_held_reread_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && $past(req) && $past(rst_n) && addr == $past(addr)) |=> rdata == '0);
endmodule

bind secret_once_store secret_once_store_chk #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .rdata(rdata), .ready(ready)
);

// File: tb/test_secret_once_store.sv
module test_secret_once_store;
  localparam int W = 32;
  localparam int N = 8;
  localparam logic [7:0] BASE = 8'h10;

  function automatic logic [W-1:0] word_of(input int i);
    return W'((i + 1) * 32'h9E3779B9) ^ 32'h0000_5A5A;
  endfunction

  function automatic logic [N*W-1:0] build();
    logic [N*W-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i*W +: W] = word_of(i);
    return v;
  endfunction

  localparam logic [N*W-1:0] SEC = build();

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [W-1:0] rdata;
  logic ready;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  secret_once_store #(.WORD_W(W), .NUM_WORDS(N), .ADDR_W(8), .BASE_ADDR(BASE), .SECRET(SEC))
    i_secret_once_store (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
                         .rdata(rdata), .ready(ready));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cs = 1'b0; we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); cs = 1'b0;
    chk({req, " ready"}, W'(ready), W'(1));
    chk({req, " data"}, rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input string req);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a;
    @(negedge clk); cs = 1'b0; we = 1'b0;
    chk({req, " ready"}, W'(ready), W'(0));
    chk({req, " data"}, rdata, '0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 reset ready", W'(ready), W'(0));
    chk("R1 reset data", rdata, '0);

    for (int i = 0; i < N; i++) rd(BASE + 8'(i), word_of(i), "R2 first read");
    for (int i = 0; i < N; i++) rd(BASE + 8'(i), '0, "R3 reread");

    do_reset();
    for (int k = 0; k < N; k++) rd(BASE + 8'((k * 5 + 3) % N), word_of((k * 5 + 3) % N), "R4 R5 scrambled");
    for (int k = 0; k < N; k++) rd(BASE + 8'(N - 1 - k), '0, "R3 reread descending");

    do_reset();
    for (int i = 0; i < N; i++) wr(BASE + 8'(i), "R7 write ignored");
    rd(BASE - 8'd1, '0, "R8 below window");
    rd(BASE + 8'(N), '0, "R8 above window");
    rd(8'h00, '0, "R8 addr zero");
    rd(8'hFF, '0, "R8 addr top");
    for (int i = 0; i < N; i += 2) rd(BASE + 8'(i), word_of(i), "R7 R8 first after noise");

    // held read on an untouched word: value, then zero, then idle
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = BASE + 8'd1;
    @(negedge clk);
    chk("R6 held ready1", W'(ready), W'(1));
    chk("R2 held first", rdata, word_of(1));
    @(negedge clk); cs = 1'b0;
    chk("R6 held ready2", W'(ready), W'(1));
    chk("R3 held second", rdata, '0);
    @(negedge clk);
    chk("R6 idle ready", W'(ready), W'(0));
    chk("R6 idle data", rdata, '0);
    for (int i = 3; i < N; i += 2) rd(BASE + 8'(i), word_of(i), "R4 odd words");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule